// File: doc/BRIEF.md
# Pipelined NTT Butterfly Unit

This block is the arithmetic core of the innermost loop of a decimation-in-frequency number theoretic transform. Each cycle it can take one pair of coefficients, a twiddle factor and a modulus, and five cycles later it returns two results. The first is the modular sum of the pair. The second is the modular difference multiplied by the twiddle and brought back into range by a word-serial Montgomery reduction. The subtraction happens before the multiplication.

Each butterfly carries its own modulus, and the pipeline has no state between butterflies. A schedule may therefore interleave transforms over different moduli. The latency is fixed and the timing is constant, so an in-place memory schedule can count on write-back within a fixed window. The 32×32 product is built from four 16×16 partial products. The reduction consumes the product 11 bits at a time, using the property that the modulus is one above a multiple of 2^11.

The twiddle is expected in the Montgomery domain, already scaled by 2^33 mod q, so the odd result comes out in the normal domain.

Top module: `ntt_bfly_pipe`

## Requirements
- R1: When left and right are both below q, even equals (left + right) mod q and is strictly below q.
- R2: When left, right and twiddle are below q, odd equals twiddle × ((left − right) mod q) × 2^-33 mod q and is strictly below q. A twiddle of 1 therefore yields the difference divided by 2^33 modulo q.
- R3: Both results appear exactly 5 cycles after the butterfly is presented. valid_o is valid_i delayed by 5 cycles, and even, odd and valid_o change on the same edge.
- R4: One butterfly is accepted every cycle with no stall. Back-to-back butterflies, idle bubbles and a different q or twiddle on each consecutive butterfly do not disturb one another's results.
- R5: The modulus has the form q = qh·2^11 + 1, meaning bits [10:0] equal 1, with a width from 22 bits (q = 2^21 + 1) up to 32 bits (q = 2^32 − 2047). Both extremes give correct results.
- R6: While rst_ni is low, valid_o, even_o and odd_o are all 0.
- R7: The internal 64-bit product of twiddle and difference equals the exact product. It is formed from four 16×16 partial products, and maximal operands under the largest modulus reduce correctly.
- R8: Boundary operands behave arithmetically. With left = right, even is 2·left mod q and odd is 0. A sum of q or more wraps, a negative difference wraps, and a twiddle of 0 gives odd = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Butterfly present on the inputs this cycle |
| left_i | input | 32 | First coefficient |
| right_i | input | 32 | Second coefficient |
| tw_i | input | 32 | Twiddle in the Montgomery domain |
| q_i | input | 32 | Modulus, bits [10:0] equal to 1 |
| valid_o | output | 1 | Results valid |
| even_o | output | 32 | Modular sum |
| odd_o | output | 32 | Reduced twiddle product of the difference |

## Verification
The sum path and the twiddle-product path retire in the same cycle. In that same cycle a new butterfly is taken in while an older one leaves. The bench streams butterflies back to back with bubbles in between. It mixes moduli from 22 to 32 bits and changes q on consecutive entries, so that one item's sum leaves alongside another item's reduction. Each output pair is compared, on the fifth cycle after its launch, with a model that forms the sum directly with the % operator and removes the Montgomery factor by 33 halvings modulo q.

// File: rtl/ntt_bfly_pkg.sv
package ntt_bfly_pkg;
  localparam int unsigned BFLY_W    = 32;
  localparam int unsigned RED_W     = 11;
  localparam int unsigned RED_ITERS = 3;
  localparam int unsigned BFLY_LAT  = 5;
endpackage

// File: rtl/ntt_bfly_addsub.sv
module ntt_bfly_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] dif_o
);
  localparam int unsigned XW = W + 3;

  logic [XW-1:0] sum0, sum1, sum2, dif0, dif1, dif2, qx;

  always_comb begin
    qx   = XW'(q_i);
    sum0 = XW'(a_i) + XW'(b_i);
    sum1 = sum0 - qx;
    sum2 = sum0 - (qx << 1);
    dif0 = XW'(a_i) - XW'(b_i);
    dif1 = dif0 + qx;
    dif2 = dif0 + (qx << 1);
    // lazy: at most two corrections, MSB is the sign
    if (sum1[XW-1])      sum_o = sum0[W-1:0];
    else if (sum2[XW-1]) sum_o = sum1[W-1:0];
    else                 sum_o = sum2[W-1:0];
    if (dif1[XW-1])      dif_o = dif2[W-1:0];
    else if (dif0[XW-1]) dif_o = dif1[W-1:0];
    else                 dif_o = dif0[W-1:0];
  end
endmodule

// File: rtl/ntt_bfly_delay.sv
module ntt_bfly_delay #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign d_o = stage_q[DEPTH-1];
endmodule

// File: rtl/ntt_bfly_mul.sv
module ntt_bfly_mul #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           v_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           v_o,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned PW = 2 * W;

  // partial product index: bit0 picks the half of a, bit1 the half of b
  logic [2*H-1:0] pp_q [4];
  logic           v1_q;

  for (genvar i = 0; i < 4; i++) begin : g_pp
    logic [H-1:0] a_half, b_half;
    assign a_half = i[0] ? a_i[W-1:H] : a_i[H-1:0];
    assign b_half = i[1] ? b_i[W-1:H] : b_i[H-1:0];
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) pp_q[i] <= '0;
      else         pp_q[i] <= a_half * b_half;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      v_o    <= 1'b0;
      prod_o <= '0;
    end else begin
      v1_q   <= v_i;
      v_o    <= v1_q;
      prod_o <= PW'(pp_q[0])
              + ((PW'(pp_q[1]) + PW'(pp_q[2])) << H)
              + (PW'(pp_q[3]) << W);
    end
  end

  a_r7_split_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> prod_o == (PW'($past(a_i, 2)) * PW'($past(b_i, 2))));
endmodule

// File: rtl/ntt_bfly_redc.sv
module ntt_bfly_redc #(
  parameter int unsigned W     = 32,
  parameter int unsigned RW    = 11,
  parameter int unsigned ITERS = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           v_i,
  input  logic [2*W-1:0] t_i,
  input  logic [W-1:0]   q_i,
  output logic           v_o,
  output logic [W-1:0]   res_o
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned HW = W - RW;

  // one word step: (t + m*q) / 2^RW with m = -t mod 2^RW, q = qh*2^RW + 1
  function automatic logic [PW-1:0] redc_step(input logic [PW-1:0] t,
                                              input logic [HW-1:0] qh);
    logic [RW-1:0] lo, m;
    lo = t[RW-1:0];
    m  = -lo;
    return (t >> RW) + PW'(qh) * PW'(m) + PW'(|lo);
  endfunction

  logic [PW-1:0] chain [ITERS];
  logic [PW-1:0] t4_q, t5;
  logic [W-1:0]  q4_q;
  logic          v4_q;

  assign chain[0] = t_i;
  for (genvar i = 0; i < ITERS - 2; i++) begin : g_iter
    assign chain[i+1] = redc_step(chain[i], q_i[W-1:RW]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t4_q <= '0;
      q4_q <= '0;
      v4_q <= 1'b0;
    end else begin
      t4_q <= redc_step(chain[ITERS-2], q_i[W-1:RW]);
      q4_q <= q_i;
      v4_q <= v_i;
    end
  end

  assign t5 = redc_step(t4_q, q4_q[W-1:RW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      v_o   <= 1'b0;
    end else begin
      res_o <= (t5 >= PW'(q4_q)) ? W'(t5 - PW'(q4_q)) : t5[W-1:0];
      v_o   <= v4_q;
    end
  end

  a_r2_odd_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> res_o < $past(q4_q));
endmodule

// File: rtl/ntt_bfly_pipe.sv
module ntt_bfly_pipe
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned W     = BFLY_W,
  parameter int unsigned RW    = RED_W,
  parameter int unsigned ITERS = RED_ITERS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic [W-1:0] tw_i,
  input  logic [W-1:0] q_i,
  output logic         valid_o,
  output logic [W-1:0] even_o,
  output logic [W-1:0] odd_o
);
  localparam int unsigned CW = $clog2(BFLY_LAT + 1);

  logic [W-1:0]   sum_c, dif_c;
  logic [W-1:0]   s1_even, s1_dif, s1_tw, s1_q, q3, q5;
  logic           s1_v, v3;
  logic [2*W-1:0] prod3;

  ntt_bfly_addsub #(.W(W)) u_addsub (
    .a_i(left_i), .b_i(right_i), .q_i(q_i), .sum_o(sum_c), .dif_o(dif_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_even <= '0;
      s1_dif  <= '0;
      s1_tw   <= '0;
      s1_q    <= '0;
      s1_v    <= 1'b0;
    end else begin
      s1_even <= sum_c;
      s1_dif  <= dif_c;
      s1_tw   <= tw_i;
      s1_q    <= q_i;
      s1_v    <= valid_i;
    end
  end

  ntt_bfly_mul #(.W(W)) u_mul (
    .clk_i, .rst_ni, .v_i(s1_v), .a_i(s1_tw), .b_i(s1_dif),
    .v_o(v3), .prod_o(prod3)
  );

  ntt_bfly_delay #(.W(W), .DEPTH(2)) u_q_dly (
    .clk_i, .rst_ni, .d_i(s1_q), .d_o(q3)
  );

  ntt_bfly_redc #(.W(W), .RW(RW), .ITERS(ITERS)) u_redc (
    .clk_i, .rst_ni, .v_i(v3), .t_i(prod3), .q_i(q3),
    .v_o(valid_o), .res_o(odd_o)
  );

  // sum path matched to the multiply/reduce depth
  ntt_bfly_delay #(.W(2*W), .DEPTH(BFLY_LAT - 1)) u_even_dly (
    .clk_i, .rst_ni, .d_i({s1_q, s1_even}), .d_o({q5, even_o})
  );

  logic [CW-1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    warm_q <= '0;
    else if (warm_q != BFLY_LAT[CW-1:0]) warm_q <= warm_q + 1'b1;

  a_r3_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == BFLY_LAT[CW-1:0]) |-> valid_o == $past(valid_i, 5));

  a_r5_mod_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (q_i[RW-1:0] == RW'(1)));

  a_r1_even_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> even_o < q5);
endmodule

// File: tb/ntt_bfly_pipe_bench.sv
`timescale 1ns/1ps
module ntt_bfly_pipe_bench;
  localparam int NMAX = 2048;
  localparam int LAT  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] left_i = '0, right_i = '0, tw_i = '0, q_i = 32'h0020_0001;
  logic        valid_o;
  logic [31:0] even_o, odd_o;

  always #5 clk = ~clk;

  ntt_bfly_pipe u_ntt_bfly_pipe (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .left_i, .right_i, .tw_i, .q_i,
    .valid_o, .even_o, .odd_o
  );

  int n_chk = 0, n_bad = 0, n_items = 0;
  logic        st_v [NMAX];
  logic [31:0] st_l [NMAX], st_r [NMAX], st_w [NMAX], st_q [NMAX];
  logic [31:0] ex_e [NMAX], ex_o [NMAX];
  string       st_tag [NMAX];

  function automatic logic [31:0] ref_even(logic [31:0] a, logic [31:0] b, logic [31:0] q);
    logic [63:0] s;
    s = 64'(a) + 64'(b);
    return 32'(s % 64'(q));
  endfunction

  function automatic logic [31:0] ref_odd(logic [31:0] a, logic [31:0] b,
                                          logic [31:0] w, logic [31:0] q);
    logic [63:0] d, p;
    d = (64'(a) + 64'(q) - 64'(b)) % 64'(q);
    p = (64'(w) * d) % 64'(q);
    for (int i = 0; i < 33; i++) p = p[0] ? (p + 64'(q)) >> 1 : p >> 1;
    return 32'(p);
  endfunction

  task automatic add_item(logic v, logic [31:0] l, logic [31:0] r,
                          logic [31:0] w, logic [31:0] q, string tag);
    st_v[n_items] = v; st_l[n_items] = l; st_r[n_items] = r;
    st_w[n_items] = w; st_q[n_items] = q; st_tag[n_items] = tag;
    ex_e[n_items] = ref_even(l, r, q);
    ex_o[n_items] = ref_odd(l, r, w, q);
    n_items++;
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  logic [31:0] mods [4] = '{32'hFFFF_F801, 32'h0020_0001, 32'h07FF_F801, 32'h7E00_0801};

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      logic [31:0] q, x;
      q = mods[k];
      x = $urandom % q;
      add_item(1, x, x, $urandom % q, q, "R8 equal operands");
      add_item(1, q - 1, q - 1, q - 1, q, "R7 max operands");
      add_item(1, 0, q - 1, q - 1, q, "R8 negative difference");
      add_item(1, q - 1, 1, 1, q, "R8 sum wraps at q");
      add_item(1, 0, 0, q - 1, q, "R8 zero operands");
      add_item(1, x, 5, 0, q, "R8 zero twiddle");
      add_item(1, 7, 3, 1, q, "R2 unit twiddle");
      add_item(1, q - 2, q - 1, q - 1, q, "R5 modulus extreme");
      for (int i = 0; i < 300; i++)
        add_item(($urandom % 4) != 0, $urandom % q, $urandom % q, $urandom % q, q,
                 "R1/R2 random with bubbles R4");
    end
    for (int i = 0; i < 300; i++) begin
      logic [31:0] q;
      q = mods[$urandom % 4];
      add_item(1, $urandom % q, $urandom % q, $urandom % q, q, "R4 mixed moduli back-to-back");
    end
    for (int i = 0; i < 8; i++) add_item(0, 0, 0, 0, 32'h0020_0001, "R3 drain");

    repeat (3) @(negedge clk);
    check("R6 valid in reset", 32'(valid_o), 32'd0);
    check("R6 even in reset", even_o, 32'd0);
    check("R6 odd in reset", odd_o, 32'd0);
    rst_n = 1'b1;

    for (int c = 0; c < n_items + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        int j;
        j = c - LAT;
        check({"R3 valid timing ", st_tag[j]}, 32'(valid_o), 32'(st_v[j]));
        if (st_v[j]) begin
          check({"R1 even ", st_tag[j]}, even_o, ex_e[j]);
          check({"R2 odd ", st_tag[j]}, odd_o, ex_o[j]);
        end
      end else begin
        check("R3 no early valid", 32'(valid_o), 32'd0);
      end
      if (c < n_items) begin
        valid_i = st_v[c]; left_i = st_l[c]; right_i = st_r[c];
        tw_i = st_w[c]; q_i = st_q[c];
      end else begin
        valid_i = 1'b0;
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule